// File: doc/BRIEF.md
# Mode-Selected Timing Mark Pulse Generator

The block drives a single registered timing mark pulse, about one millisecond long, after a measurement tick arrives. A one-cycle arm strobe first moves the block out of idle. The next tick is then held until the first enable of an internal coarse grid. That grid comes from a free-running divider clocked by the master clock. The leading edge of the mark therefore always sits on the grid, at a cost of up to one grid period of jitter with respect to the tick.

A mode input selects real-input or complex-input operation. Real-input mode uses a 7-cycle grid and a 40000-cycle pulse, which is 1.0000000 ms at a 40 MHz master clock. Complex-input mode uses a 6-cycle grid and a 34999-cycle pulse, which is 0.9999714 ms at 35 MHz. The mode is copied into an internal register only while no pulse is active. That copy drives both the grid and the pulse length.

The controller has four states:
- IDLE: waits for arm.
- ARMED: waits for tick.
- PENDING: tick captured, waiting for the grid enable.
- PULSE: the mark is high.

The transitions are:
- IDLE→ARMED on arm.
- ARMED→PENDING on tick.
- PENDING→PULSE on a grid enable.
- PULSE→IDLE when the length counter reaches its last cycle.

Every other case holds the current state.

Top module: `tmark_gen`

## Requirements
- R1: After reset the mark is low, the controller is in IDLE, the grid divider is at count 0 and the latched mode is real-input (0).
- R2: With mode_cplx_i = 0 the grid enable repeats every 7 master-clock cycles.
- R3: With mode_cplx_i = 1 the grid enable repeats every 6 master-clock cycles.
- R4: In real-input mode the mark stays high for exactly 40000 consecutive cycles.
- R5: In complex-input mode the mark stays high for exactly 34999 consecutive cycles.
- R6: When a tick is sampled while ARMED, the mark rises in the cycle after the first grid enable that follows the tick's sampling edge. The delay from tick to mark therefore never exceeds one grid period plus one register stage.
- R7: A tick sampled while IDLE (not armed) has no effect, and the mark stays low.
- R8: A tick sampled during an active pulse neither extends nor restarts the pulse.
- R9: A change of mode_cplx_i during an active pulse does not alter that pulse's length. The change takes effect only after the mark has fallen.
- R10: If the tick is sampled on the same edge as a grid enable, that enable does not fire the pulse. The pulse starts on the following enable, so the mark rises one grid period plus one cycle after the tick edge.
- R11: Each arm yields at most one pulse. An arm sampled during a pulse is ignored, so a tick after the pulse has ended does not fire.
- R12: The mark is the output of a flip-flop and changes only after a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_cplx_i | input | 1 | 0 selects real-input mode, 1 selects complex-input mode |
| arm_i | input | 1 | One-cycle strobe that arms the block for the next tick |
| tick_i | input | 1 | One-cycle measurement tick strobe |
| mark_o | output | 1 | Registered timing mark pulse |

## Verification
Two events can land on the same clock edge: the tick being sampled and the grid enable firing. When they coincide, the block must let that enable pass and wait one full period (R10). The bench provokes this on purpose. It keeps a reference model of the grid divider and waits until the model shows the terminal count before it raises the tick. It then requires the mark to rise exactly grid+1 cycles later. Every other tick is placed at a random offset, and its latency is judged against the same model. A second overlap is a tick or arm arriving while the mark is high. The bench checks that the pulse length is unchanged and that no further pulse follows.

// File: rtl/tmark_pkg.sv
package tmark_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_PENDING = 2'd2,
        ST_PULSE   = 2'd3
    } tm_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tmark_grid.sv
module tmark_grid #(
    parameter int unsigned GRID_REAL = 7,
    parameter int unsigned GRID_CPLX = 6
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic mode_cplx_i,
    output logic grid_en_o
);
    import tmark_pkg::*;

    localparam int unsigned GMAX = max2(GRID_REAL, GRID_CPLX);
    localparam int unsigned CW   = (GMAX > 2) ? $clog2(GMAX) : 1;
    localparam logic [CW-1:0] TERM_REAL = CW'(GRID_REAL - 1);
    localparam logic [CW-1:0] TERM_CPLX = CW'(GRID_CPLX - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] term;

    always_comb begin
        term      = mode_cplx_i ? TERM_CPLX : TERM_REAL;
        grid_en_o = (cnt_q >= term);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (grid_en_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_grid_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grid_en_o |=> (cnt_q == '0));

    p_grid_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CW'(GMAX - 1));

endmodule

// File: rtl/tmark_width.sv
module tmark_width #(
    parameter int unsigned WIDTH_REAL = 40000,
    parameter int unsigned WIDTH_CPLX = 34999
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic busy_i,
    input  logic mode_cplx_i,
    output logic last_o
);
    import tmark_pkg::*;

    localparam int unsigned WMAX = max2(WIDTH_REAL, WIDTH_CPLX);
    localparam int unsigned CW   = (WMAX > 2) ? $clog2(WMAX) : 1;
    localparam logic [CW-1:0] INIT_REAL = CW'(WIDTH_REAL - 1);
    localparam logic [CW-1:0] INIT_CPLX = CW'(WIDTH_CPLX - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= mode_cplx_i ? INIT_CPLX : INIT_REAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = busy_i && (cnt_q == '0);

    p_width_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && !last_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

    p_width_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (cnt_q == (mode_cplx_i ? INIT_CPLX : INIT_REAL)) || $past(mode_cplx_i) != mode_cplx_i);

endmodule

// File: rtl/tmark_ctrl.sv
module tmark_ctrl (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 arm_i,
    input  logic                 tick_i,
    input  logic                 grid_en_i,
    input  logic                 last_i,
    output tmark_pkg::tm_state_e state_o,
    output tmark_pkg::tm_state_e state_nxt_o,
    output logic                 load_o
);
    import tmark_pkg::*;

    tm_state_e state_q;
    tm_state_e state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:    if (arm_i)  state_d = ST_ARMED;
            ST_ARMED:   if (tick_i) state_d = ST_PENDING;
            ST_PENDING: begin
                if (grid_en_i) begin
                    state_d = ST_PULSE;
                    load_o  = 1'b1;
                end
            end
            ST_PULSE:   if (last_i) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign state_o     = state_q;
    assign state_nxt_o = state_d;

    p_pend_wait_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_PENDING && !grid_en_i) |=> (state_q == ST_PENDING));

    p_idle_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE && !arm_i) |=> (state_q == ST_IDLE));

    p_pulse_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_PULSE && !last_i) |=> (state_q == ST_PULSE));

endmodule

// File: rtl/tmark_gen.sv
module tmark_gen #(
    parameter int unsigned GRID_REAL  = 7,
    parameter int unsigned GRID_CPLX  = 6,
    parameter int unsigned WIDTH_REAL = 40000,
    parameter int unsigned WIDTH_CPLX = 34999
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic mode_cplx_i,
    input  logic arm_i,
    input  logic tick_i,
    output logic mark_o
);
    import tmark_pkg::*;

    tm_state_e state;
    tm_state_e state_nxt;
    logic      mode_q;
    logic      grid_en;
    logic      last;
    logic      load;
    logic      mark_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mode_q <= 1'b0;
        end else if (state != ST_PULSE) begin
            mode_q <= mode_cplx_i;
        end
    end

    tmark_grid #(
        .GRID_REAL (GRID_REAL),
        .GRID_CPLX (GRID_CPLX)
    ) u_grid (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .mode_cplx_i (mode_q),
        .grid_en_o   (grid_en)
    );

    tmark_width #(
        .WIDTH_REAL (WIDTH_REAL),
        .WIDTH_CPLX (WIDTH_CPLX)
    ) u_width (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (load),
        .busy_i      (state == ST_PULSE),
        .mode_cplx_i (mode_q),
        .last_o      (last)
    );

    tmark_ctrl u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .arm_i       (arm_i),
        .tick_i      (tick_i),
        .grid_en_i   (grid_en),
        .last_i      (last),
        .state_o     (state),
        .state_nxt_o (state_nxt),
        .load_o      (load)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mark_q <= 1'b0;
        end else begin
            mark_q <= (state_nxt == ST_PULSE);
        end
    end

    assign mark_o = mark_q;

    p_rise_on_grid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mark_q) |-> $past(state == ST_PENDING && grid_en));

    p_mode_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_PULSE) |=> $stable(mode_q));

    p_fall_to_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(mark_q) |-> (state == ST_IDLE));

    p_mark_tracks_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mark_q == (state == ST_PULSE));

endmodule

// File: tb/test_tmark_gen.sv
module test_tmark_gen;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b0;
    logic arm = 1'b0;
    logic tick = 1'b0;
    logic mark;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_cnt;
    logic m_mode;

    always #10 clk = ~clk;

    tmark_gen i_tmark_gen (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .mode_cplx_i (mode),
        .arm_i       (arm),
        .tick_i      (tick),
        .mark_o      (mark)
    );

    function automatic int grid_len(input logic m);
        return m ? 6 : 7;
    endfunction

    function automatic int pulse_len(input logic m);
        return m ? 34999 : 40000;
    endfunction

    function automatic int tick_latency(input int c, input int p);
        int nxt;
        nxt = (c >= p - 1) ? 0 : c + 1;
        return 2 + (p - 1 - nxt);
    endfunction

    // Reference grid model built from R1-style reset and the R2/R3 periods.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt  <= 0;
            m_mode <= 1'b0;
        end else begin
            m_cnt <= (m_cnt >= grid_len(m_mode) - 1) ? 0 : m_cnt + 1;
            if (!mark) m_mode <= mode;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_cycles(input int n, input string req);
        int hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (mark) hi++;
        end
        check(req, hi, 0);
    endtask

    task automatic run_pulse(input bit on_edge, input bit inject, input bit flip,
                             input string lat_req, input string w_req);
        int p, w, c, exp_lat, n, wc;
        @(negedge clk);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        repeat ($urandom_range(0, 9)) @(negedge clk);
        if (on_edge) begin
            while (m_cnt < grid_len(m_mode) - 1) @(negedge clk);
        end
        p = grid_len(m_mode);
        w = pulse_len(m_mode);
        c = m_cnt;
        exp_lat = tick_latency(c, p);
        tick = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            tick = 1'b0;
            n++;
        end while (!mark && n < 50);
        check(lat_req, n, exp_lat);
        wc = 0;
        while (mark && wc < 50000) begin
            if (inject && wc == 100) begin tick = 1'b1; arm = 1'b1; end
            if (inject && wc == 101) begin tick = 1'b0; arm = 1'b0; end
            if (flip && wc == 200) mode = ~mode;
            @(negedge clk);
            wc++;
        end
        check(w_req, wc, w);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        check("R1 mark low in reset", int'(mark), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mark low after reset", int'(mark), 0);

        // R7: random ticks while idle never fire
        for (int i = 0; i < 20; i++) begin
            repeat ($urandom_range(1, 12)) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
        idle_cycles(20, "R7 idle tick ignored");

        // Real mode, R2/R6 latency, R4 width, R8/R11 injected tick+arm during pulse
        run_pulse(1'b0, 1'b1, 1'b0, "R2 R6 real latency", "R4 R8 real width");
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        idle_cycles(30, "R11 no second pulse per arm");

        // Complex mode, R10 tick on grid enable, R9 mode flip mid pulse, R5 width
        mode = 1'b1;
        repeat (3) @(negedge clk);
        run_pulse(1'b1, 1'b0, 1'b1, "R3 R10 tick on enable", "R5 R9 complex width");
        check("R12 mark low after pulse", int'(mark), 0);

        // Mode now real again (flipped during pulse); random offset real pulse
        repeat (3) @(negedge clk);
        run_pulse(1'b0, 1'b0, 1'b0, "R6 R9 random real latency", "R4 R9 width after flip");
        idle_cycles(10, "R11 idle after last pulse");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule